// File: doc/BRIEF.md
# Digital Audio Subframe Formatter

This block assembles the 32-bit subframes of a consumer two-channel digital audio link from stereo samples. A producer offers one left/right sample pair at a time, along with a flag that marks the pair as unreliable and a select that narrows the sample to 16 significant bits. Once a pair is accepted, the block emits two subframes on consecutive cycles: channel 1 (left) and then channel 2 (right). Each subframe is a 28-bit payload carrying wire bits 4 to 31, a preamble type code and a one-cycle strobe. The line coder that follows turns these into bi-phase symbols. Serialization and symbol coding sit outside this block.

The block keeps its place inside the 192-frame block. It takes one bit per frame from a 192-bit user word and one from a 192-bit channel-status word, both held steady by the surrounding logic. It chooses the preamble type for every subframe. When the status word declares consumer use, it rewrites the four channel-identification status bits for each subframe according to a stereo-mode input.

The control is a three-state machine:
- ST_IDLE waits for a sample and holds the ready output high.
- ST_CH1 emits the channel 1 subframe.
- ST_CH2 emits the channel 2 subframe and advances the frame position.

There are four transitions: IDLE→CH1 on an accepted sample, IDLE→IDLE while no sample is offered, CH1→CH2 always, and CH2→IDLE always. A synchronous reset forces ST_IDLE and frame 0.

Top module: `aud_sf_fmt`

## Requirements
- R1: While reset is held and on the first cycle after it, `smp_ready` is 1 and `sf_strobe` is 0. The frame position is 0, so the next channel 1 subframe carries the block preamble.
- R2: A pair is accepted on a clock edge where `smp_valid` and `smp_ready` are both 1. `sf_strobe` is then high for exactly the next two cycles, with `smp_ready` low during both, and is low again on the cycle after.
- R3: `sf_pre` is 0 (block start) on the channel 1 subframe of frame 0, 1 (channel 1) on the channel 1 subframe of every other frame, and 2 (channel 2) on every channel 2 subframe.
- R4: `sf_payload[23:0]` is the left sample in the first subframe and the right sample in the second. Payload bit 0 is wire bit 4 and bit 23 is wire bit 27, the sample MSB.
- R5: When `short_mode` was 1 at acceptance, `sf_payload[7:0]` is zero in both subframes of that frame.
- R6: `sf_payload[24]` equals the `smp_unrel` value captured at acceptance, in both subframes.
- R7: `sf_payload[25]` equals `user_word[k]` in both subframes of frame k.
- R8: `sf_payload[26]` equals `cs_word[k]` in both subframes of frame k, unless R9 applies.
- R9: When `cs_word[0]` is 0 and k is 20 to 23, the status bit is replaced. With `stereo_en` = 1 it is 1 only for k = 20 in channel 1 and only for k = 21 in channel 2. With `stereo_en` = 0 it is 0.
- R10: `sf_payload[27]` makes the number of ones in `sf_payload[27:0]` even.
- R11: The frame position advances by one after each channel 2 subframe and wraps from 191 to 0, so the block preamble returns every 192 frames.
- R12: `smp_valid` while `smp_ready` is 0 is ignored. No extra subframe follows, and the held sample does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Block can accept a pair this cycle |
| smp_left | input | 24 | Left (channel 1) sample, two's complement |
| smp_right | input | 24 | Right (channel 2) sample, two's complement |
| smp_unrel | input | 1 | Pair is unreliable; captured with the pair |
| short_mode | input | 1 | Pair carries 16 significant bits; captured with the pair |
| stereo_en | input | 1 | Selects stereo channel identification in consumer status |
| user_word | input | 192 | User data word, bit k sent in frame k |
| cs_word | input | 192 | Channel-status word, bit k sent in frame k |
| sf_strobe | output | 1 | A subframe is presented this cycle |
| sf_pre | output | 2 | Preamble type: 0 block start, 1 channel 1, 2 channel 2 |
| sf_payload | output | 28 | Wire bits 4..31: sample, validity, user, status, parity |

## Verification
The hardest state to reach is the channel-identification override. It only shows up in frames 20 to 23, and only when the status word declares consumer use. It also needs both settings of the stereo control, and its effect differs between the two subframes of the same frame. The stimulus runs for more than three full blocks. It toggles `stereo_en` every few hundred cycles and refills the status word with random bits, clearing bit 0 except during one window where it is forced high. Frames 20 to 23 are therefore seen with consumer and professional status and with stereo on and off. Random status values in those positions show that the override really replaces them. A reset in the middle of a block, while `smp_valid` is held high, shows that the block preamble restarts.

// File: rtl/aud_sf_pkg.sv
package aud_sf_pkg;

    // Preamble type codes seen by the line coder.
    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_CH1   = 2'd1,
        PRE_CH2   = 2'd2
    } pre_e;

    // Formatter control states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CH1  = 2'd1,
        ST_CH2  = 2'd2
    } st_e;

    // Per-pair flags captured at acceptance.
    typedef struct packed {
        logic unrel;
        logic short_mode;
    } pair_flags_t;

endpackage

// File: rtl/aud_sf_blkpos.sv
module aud_sf_blkpos #(
    parameter int FRAMES = 192,
    localparam int FW    = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [FW-1:0] frame,
    output logic          at_start
);

    localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (adv) begin
            if (frame == LAST) frame <= '0;
            else               frame <= frame + 1'b1;
        end
    end

    assign at_start = (frame == '0);

endmodule

// File: rtl/aud_sf_chbits.sv
module aud_sf_chbits #(
    parameter int FRAMES   = 192,
    parameter int ID_FIRST = 20,
    parameter int ID_LEN   = 4,
    localparam int FW      = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0] cs_word,
    input  logic [FRAMES-1:0] user_word,
    input  logic [FW-1:0]     frame,
    input  logic              second,
    input  logic              stereo_en,
    output logic              cs_bit,
    output logic              user_bit
);

    localparam logic [FW-1:0] ID_LO   = FW'(ID_FIRST);
    localparam logic [FW-1:0] ID_HI   = FW'(ID_FIRST + ID_LEN - 1);
    localparam logic [FW-1:0] ID_LEFT = FW'(ID_FIRST);
    localparam logic [FW-1:0] ID_RGHT = FW'(ID_FIRST + 1);

    logic consumer;
    logic in_id;
    logic id_val;

    always_comb begin
        consumer = ~cs_word[0];
        in_id    = consumer && (frame >= ID_LO) && (frame <= ID_HI);
        id_val   = stereo_en && (frame == (second ? ID_RGHT : ID_LEFT));
        cs_bit   = in_id ? id_val : cs_word[frame];
        user_bit = user_word[frame];
    end

endmodule

// File: rtl/aud_sf_pack.sv
module aud_sf_pack #(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    localparam int PW      = SAMPLE_W + 4,
    localparam int DROP    = SAMPLE_W - SHORT_W
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                short_mode,
    input  logic                unrel,
    input  logic                user_bit,
    input  logic                cs_bit,
    output logic [PW-1:0]       payload
);

    logic [SAMPLE_W-1:0] smp_m;
    logic [PW-2:0]       body;

    for (genvar i = 0; i < SAMPLE_W; i++) begin : g_mask
        if (i < DROP) begin : g_low
            assign smp_m[i] = sample[i] & ~short_mode;
        end else begin : g_high
            assign smp_m[i] = sample[i];
        end
    end

    assign body    = {cs_bit, user_bit, unrel, smp_m};
    assign payload = {^body, body};

endmodule

// File: rtl/aud_sf_fmt.sv
module aud_sf_fmt
    import aud_sf_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int FRAMES   = 192,
    parameter int ID_FIRST = 20,
    localparam int PAY_W   = SAMPLE_W + 4,
    localparam int FW      = $clog2(FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_unrel,
    input  logic                short_mode,
    input  logic                stereo_en,
    input  logic [FRAMES-1:0]   user_word,
    input  logic [FRAMES-1:0]   cs_word,
    output logic                sf_strobe,
    output logic [1:0]          sf_pre,
    output logic [PAY_W-1:0]    sf_payload
);

    st_e                 state;
    st_e                 state_nx;
    logic [SAMPLE_W-1:0] hold_l;
    logic [SAMPLE_W-1:0] hold_r;
    pair_flags_t         hold_f;
    logic                accept;
    logic                adv;
    logic [FW-1:0]       frame;
    logic                at_start;
    logic                second;
    logic [SAMPLE_W-1:0] cur_smp;
    pre_e                pre;
    logic                cs_bit;
    logic                user_bit;

    assign accept = (state == ST_IDLE) && smp_valid;
    assign adv    = (state == ST_CH2);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = smp_valid ? ST_CH1 : ST_IDLE;
            ST_CH1:  state_nx = ST_CH2;
            ST_CH2:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Sample holding registers, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            hold_f <= '0;
        end else if (accept) begin
            hold_l <= smp_left;
            hold_r <= smp_right;
            hold_f <= '{unrel: smp_unrel, short_mode: short_mode};
        end
    end

    // Outputs decoded from state.
    always_comb begin
        smp_ready = 1'b0;
        sf_strobe = 1'b0;
        second    = 1'b0;
        cur_smp   = hold_l;
        pre       = PRE_CH1;
        unique case (state)
            ST_IDLE: begin
                smp_ready = 1'b1;
            end
            ST_CH1: begin
                sf_strobe = 1'b1;
                pre       = at_start ? PRE_BLOCK : PRE_CH1;
            end
            ST_CH2: begin
                sf_strobe = 1'b1;
                second    = 1'b1;
                cur_smp   = hold_r;
                pre       = PRE_CH2;
            end
            default: begin
                smp_ready = 1'b0;
            end
        endcase
    end

    assign sf_pre = pre;

    aud_sf_blkpos #(.FRAMES(FRAMES)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .frame    (frame),
        .at_start (at_start)
    );

    aud_sf_chbits #(.FRAMES(FRAMES), .ID_FIRST(ID_FIRST), .ID_LEN(4)) u_bits (
        .cs_word   (cs_word),
        .user_word (user_word),
        .frame     (frame),
        .second    (second),
        .stereo_en (stereo_en),
        .cs_bit    (cs_bit),
        .user_bit  (user_bit)
    );

    aud_sf_pack #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_pack (
        .sample     (cur_smp),
        .short_mode (hold_f.short_mode),
        .unrel      (hold_f.unrel),
        .user_bit   (user_bit),
        .cs_bit     (cs_bit),
        .payload    (sf_payload)
    );

endmodule

// File: rtl/aud_sf_chk.sv
module aud_sf_chk #(
    parameter int PW = 28
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_ready,
    input logic          sf_strobe,
    input logic [1:0]    sf_pre,
    input logic [PW-1:0] sf_payload
);

    // R2: a channel 1 subframe is always followed by a channel 2 subframe
    a_r2_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && sf_pre != 2'd2) |=> (sf_strobe && sf_pre == 2'd2));

    // R2: after channel 2 the block returns to accepting
    a_r2_return: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && sf_pre == 2'd2) |=> (!sf_strobe && smp_ready));

    // R3: the first subframe after an idle cycle never carries the channel 2 code
    a_r3_first_not_w: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_ready) && sf_strobe) |-> (sf_pre != 2'd2));

    // R3: code 3 is never produced
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sf_strobe |-> (sf_pre != 2'd3));

    // R10: even parity across the whole payload
    a_r10_parity: assert property (@(posedge clk) disable iff (!rst_n)
        sf_strobe |-> ($countones(sf_payload) % 2 == 0));

    // R6: validity is the same in both subframes of one frame
    a_r6_valid_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && sf_pre == 2'd2) |-> (sf_payload[PW-4] == $past(sf_payload[PW-4])));

endmodule

bind aud_sf_fmt aud_sf_chk #(.PW(PAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_ready  (smp_ready),
    .sf_strobe  (sf_strobe),
    .sf_pre     (sf_pre),
    .sf_payload (sf_payload)
);

// File: tb/tb_aud_sf_fmt.sv
module tb_aud_sf_fmt;

    localparam int FR     = 192;
    localparam int NCYC   = 2400;
    localparam int WD_LIM = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [23:0]   smp_left = '0;
    logic [23:0]   smp_right = '0;
    logic          smp_unrel = 1'b0;
    logic          short_mode = 1'b0;
    logic          stereo_en = 1'b0;
    logic [FR-1:0] user_word = '0;
    logic [FR-1:0] cs_word = '0;
    logic          sf_strobe;
    logic [1:0]    sf_pre;
    logic [27:0]   sf_payload;

    always #2.5 clk = ~clk;

    aud_sf_fmt dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right), .smp_unrel(smp_unrel),
        .short_mode(short_mode), .stereo_en(stereo_en), .user_word(user_word),
        .cs_word(cs_word), .sf_strobe(sf_strobe), .sf_pre(sf_pre), .sf_payload(sf_payload)
    );

    int  total = 0;
    int  fails = 0;
    bit  done  = 0;

    // Behavioural model state
    int          m_st = 0;
    int          m_fr = 0;
    bit          m_wrapped = 0;
    logic [23:0] m_l = '0;
    logic [23:0] m_r = '0;
    bit          m_v = 0;
    bit          m_s = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FR-1:0] rand_word();
        logic [FR-1:0] w;
        for (int i = 0; i < FR / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic compare();
        bit          sec;
        bit          st_bit;
        bit          ovr;
        logic [23:0] smp;
        logic [1:0]  exp_pre;
        bit          par;
        string       rq;
        rq = (m_st != 0 && smp_valid) ? "R12" : "R2";
        if (!rst_n) rq = "R1";
        chk(smp_ready == (m_st == 0), rq, "ready", smp_ready, m_st == 0);
        chk(sf_strobe == (m_st != 0), rq, "strobe", sf_strobe, m_st != 0);
        if (m_st == 0) return;
        sec = (m_st == 2);
        exp_pre = sec ? 2'd2 : ((m_fr == 0) ? 2'd0 : 2'd1);
        chk(sf_pre == exp_pre, (m_fr == 0 && m_wrapped && !sec) ? "R11" : "R3",
            "preamble", sf_pre, exp_pre);
        smp = sec ? m_r : m_l;
        if (m_s) smp[7:0] = 8'h00;
        chk(sf_payload[23:0] == smp, m_s ? "R5" : "R4", "sample",
            sf_payload[23:0], smp);
        chk(sf_payload[24] == m_v, "R6", "validity", sf_payload[24], m_v);
        chk(sf_payload[25] == user_word[m_fr], "R7", "user", sf_payload[25], user_word[m_fr]);
        ovr    = !cs_word[0] && m_fr >= 20 && m_fr <= 23;
        st_bit = ovr ? (stereo_en && m_fr == (sec ? 21 : 20)) : cs_word[m_fr];
        chk(sf_payload[26] == st_bit, ovr ? "R9" : "R8", "status", sf_payload[26], st_bit);
        par = 0;
        for (int i = 0; i < 27; i++) par ^= sf_payload[i];
        chk(sf_payload[27] == par, "R10", "parity", sf_payload[27], par);
    endtask

    task automatic drive(input int cyc);
        rst_n      = !(cyc < 4 || cyc == 1500 || cyc == 1501);
        if (cyc >= 1200 && cyc < 1800) smp_valid = 1'b1;
        else smp_valid = ($urandom % 4) != 0;
        smp_left   = 24'($urandom);
        smp_right  = 24'($urandom);
        smp_unrel  = $urandom % 2;
        short_mode = ($urandom % 3) == 0;
        if (cyc % 300 == 0) stereo_en = ~stereo_en;
        if (cyc % 500 == 0) user_word = rand_word();
        if (cyc % 250 == 0) begin
            cs_word    = rand_word();
            cs_word[0] = (cyc >= 900 && cyc < 1200);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0;
            m_fr = 0;
            m_wrapped = 0;
        end else if (m_st == 0) begin
            if (smp_valid) begin
                m_l = smp_left; m_r = smp_right; m_v = smp_unrel; m_s = short_mode;
                m_st = 1;
            end
        end else if (m_st == 1) begin
            m_st = 2;
        end else begin
            m_st = 0;
            if (m_fr == FR - 1) begin
                m_fr = 0;
                m_wrapped = 1;
            end else begin
                m_fr++;
            end
        end
    endtask

    initial begin
        user_word = rand_word();
        cs_word   = rand_word();
        cs_word[0] = 1'b0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            compare();
            drive(cyc);
            model_step();
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule